// File: doc/BRIEF.md
# Serial Peripheral Slave Select and Three-Wire Framing Control

This block is the slave-side front end of a serial peripheral port. It decides when a slave transaction begins and when it is over, and it leaves the movement of data bits to a separate shift datapath. The block synchronizes the raw select pin and the raw serial clock pin into the system clock domain. It counts serial clock rising edges inside each transaction, and it keeps the status flags that software reads: a sticky done flag, a length-met flag, and a three-wire start status with an interrupt output.

The select pin can work in three ways. In edge mode a transaction opens on the active transition of select and closes once the configured number of bits has arrived. In level mode a transaction lasts as long as select is held at its active level. In three-wire mode the select pin is ignored: the first serial clock edge opens the transaction, and software may abort a transfer that stops short. A polarity bit chooses which select level, or which edge, counts as active. Software actions (done clear, start clear, abort) are single-cycle pulse inputs. The block has no data stream, so every pin is a plain control or status signal.

Top module: `spi_ssel_frontend`

## Requirements
- R1: While reset is asserted and directly after it, busy, done_flag, len_met, start_sts, start_irq and bit_cnt are all 0. Pin edges during the synchronizer warm-up after reset start no transaction.
- R2: ssel_act_high = 0 makes a low select level (or a falling edge) active. ssel_act_high = 1 makes a high level (or a rising edge) active.
- R3: Edge mode (level_mode = 0, three_wire = 0): a transaction starts only on an active select transition. It ends, setting done_flag and clearing busy, on the serial clock rising edge that brings bit_cnt to the word length. After that, further clocks with select still active change nothing.
- R4: Level mode (level_mode = 1, three_wire = 0): busy follows the active select level. Reaching the word length sets done_flag but keeps busy, and bit_cnt stops counting until select goes inactive.
- R5: In level mode, when select goes inactive, len_met is loaded with 1 if the word length was reached in that transaction, else 0. len_met is otherwise held.
- R6: In level mode, select going inactive also sets done_flag when inactive_done_en = 1, and leaves done_flag unchanged when it is 0.
- R7: Three-wire mode (three_wire = 1, used together with level_mode = 1) ignores the select pin. The first serial clock rising edge while idle starts the transaction and counts as bit 1. Completion sets done_flag and clears busy, and loads len_met with 1.
- R8: start_sts sets when a three-wire transaction starts. It clears on completion, on abort, or on a start_clr pulse. start_irq equals start_sts when start_ie = 1 and stays 0 when start_ie = 0.
- R9: An abort pulse during a busy three-wire transaction ends it at once: busy 0, done_flag 1, len_met 0, start_sts 0. In any other case the pulse has no effect.
- R10: word_len = 0 selects a word of MAX_BITS (32) bits. Any other value gives that many bits.
- R11: A done_clr pulse clears done_flag. If a set and a clear arrive in the same cycle, the set wins.
- R12: bit_cnt resets at each transaction start and counts the synchronized rising edges of the serial clock while the transaction is counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssel_pin | input | 1 | Raw select pin (asynchronous) |
| sclk_pin | input | 1 | Raw serial clock pin (asynchronous) |
| ssel_act_high | input | 1 | Select polarity: 1 active high / rising |
| level_mode | input | 1 | 1 level-triggered select, 0 edge-triggered |
| three_wire | input | 1 | 1 ignores select, clock-started transfers |
| inactive_done_en | input | 1 | Level mode: select release sets done |
| start_ie | input | 1 | Enables start_irq |
| word_len | input | 5 | Bits per word, 0 means 32 |
| done_clr | input | 1 | Pulse: clear done_flag |
| start_clr | input | 1 | Pulse: clear start_sts |
| abort | input | 1 | Pulse: force three-wire completion |
| busy | output | 1 | A transaction is open |
| done_flag | output | 1 | Sticky transfer-done flag |
| len_met | output | 1 | Last closed transaction reached the word length |
| start_sts | output | 1 | Three-wire transaction has started |
| start_irq | output | 1 | Start interrupt request |
| bit_cnt | output | 6 | Bits counted in current/last transaction |

## Verification
The hardest state to reach from the ports is a level-mode transaction that is full but still open. Here the word length has been reached and select is still held, so extra clocks must be ignored, and releasing select later must load len_met with 1. The stimulus holds select high, sends more clock pulses than the word length, and checks bit_cnt and busy before releasing select. A three-wire abort is likewise reached only after a partial burst of clocks that stops, followed by a start_clr pulse. The abort pulse then comes while the transaction is still busy.

// File: rtl/spi_ssel_pkg.sv
package spi_ssel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_FILLED = 2'd2
  } sel_state_e;

  typedef struct packed {
    logic act_high;
    logic level;
    logic three_wire;
    logic inactive_done;
    logic start_ie;
  } sel_cfg_t;
endpackage

// File: rtl/spi_ssel_sync.sv
module spi_ssel_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic             primed_o
);
  logic [STAGES:0] warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= {warm_q[STAGES-1:0], 1'b1};
  end
  assign primed_o = warm_q[STAGES];

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-1:0], raw_i[g]};
    end
    assign lvl_o[g]  = pipe_q[STAGES-1];
    assign rise_o[g] = primed_o & pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end
endmodule

// File: rtl/spi_ssel_count.sv
module spi_ssel_count #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             counting_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit_o   = counting_i & edge_i & (cnt_inc == len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (start_i)             cnt_q <= edge_i ? CNT_W'(1) : '0;
    else if (counting_i && edge_i) cnt_q <= cnt_inc;
  end
  assign cnt_o = cnt_q;
endmodule

// File: rtl/spi_ssel_ctrl.sv
module spi_ssel_ctrl
  import spi_ssel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sel_cfg_t   cfg_i,
  input  logic       ssel_lvl_i,
  input  logic       sclk_rise_i,
  input  logic       primed_i,
  input  logic       abort_i,
  input  logic       hit_i,
  output sel_state_e state_o,
  output logic       start_o,
  output logic       counting_o,
  output logic       leave_o,
  output logic       end3_o,
  output logic       abort_end_o
);
  sel_state_e state_q, state_d;
  logic       ss_act, ss_act_q, edge_start;

  assign ss_act     = primed_i & (cfg_i.act_high ? ssel_lvl_i : ~ssel_lvl_i);
  assign edge_start = ss_act & ~ss_act_q;
  assign counting_o = (state_q == ST_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_act_q <= 1'b0;
    else        ss_act_q <= ss_act;
  end

  always_comb begin
    state_d     = state_q;
    start_o     = 1'b0;
    leave_o     = 1'b0;
    end3_o      = 1'b0;
    abort_end_o = 1'b0;
    if (cfg_i.three_wire) begin
      if (state_q == ST_IDLE) begin
        if (sclk_rise_i) begin
          start_o = 1'b1;
          state_d = ST_BUSY;
        end
      end else if (abort_i || hit_i) begin
        end3_o      = 1'b1;
        abort_end_o = abort_i & ~hit_i;
        state_d     = ST_IDLE;
      end
    end else if (cfg_i.level) begin
      if (state_q == ST_IDLE) begin
        if (ss_act) begin
          start_o = 1'b1;
          state_d = ST_BUSY;
        end
      end else if (!ss_act) begin
        leave_o = 1'b1;
        state_d = ST_IDLE;
      end else if (hit_i) begin
        state_d = ST_FILLED;
      end
    end else begin
      if (state_q == ST_IDLE) begin
        if (edge_start) begin
          start_o = 1'b1;
          state_d = ST_BUSY;
        end
      end else if (hit_i || state_q == ST_FILLED) begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
  assign state_o = state_q;
endmodule

// File: rtl/spi_ssel_flags.sv
module spi_ssel_flags
  import spi_ssel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sel_cfg_t cfg_i,
  input  logic     start_i,
  input  logic     hit_i,
  input  logic     leave_i,
  input  logic     filled_i,
  input  logic     end3_i,
  input  logic     abort_end_i,
  input  logic     done_clr_i,
  input  logic     start_clr_i,
  output logic     done_o,
  output logic     met_o,
  output logic     start_sts_o,
  output logic     start_irq_o
);
  logic done_q, met_q, sts_q, done_set;

  assign done_set = hit_i | abort_end_i | (leave_i & cfg_i.inactive_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      met_q  <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      if (done_set)        done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;

      if (leave_i)     met_q <= filled_i | hit_i;
      else if (end3_i) met_q <= hit_i;

      if (start_i && cfg_i.three_wire) sts_q <= 1'b1;
      else if (end3_i || start_clr_i)  sts_q <= 1'b0;
    end
  end

  assign done_o      = done_q;
  assign met_o       = met_q;
  assign start_sts_o = sts_q;
  assign start_irq_o = sts_q & cfg_i.start_ie;
endmodule

// File: rtl/spi_ssel_frontend.sv
module spi_ssel_frontend
  import spi_ssel_pkg::*;
#(
  parameter int MAX_BITS    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(MAX_BITS),
  localparam int CNT_W      = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ssel_pin,
  input  logic             sclk_pin,
  input  logic             ssel_act_high,
  input  logic             level_mode,
  input  logic             three_wire,
  input  logic             inactive_done_en,
  input  logic             start_ie,
  input  logic [LEN_W-1:0] word_len,
  input  logic             done_clr,
  input  logic             start_clr,
  input  logic             abort,
  output logic             busy,
  output logic             done_flag,
  output logic             len_met,
  output logic             start_sts,
  output logic             start_irq,
  output logic [CNT_W-1:0] bit_cnt
);
  sel_cfg_t   cfg;
  logic [1:0] sync_lvl, sync_rise;
  logic       primed, start, counting, leave, end3, abort_end, hit;
  logic [CNT_W-1:0] len_eff;
  sel_state_e state;

  assign cfg = '{act_high: ssel_act_high, level: level_mode, three_wire: three_wire,
                 inactive_done: inactive_done_en, start_ie: start_ie};
  assign len_eff = (word_len == '0) ? CNT_W'(MAX_BITS) : CNT_W'(word_len);

  spi_ssel_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({sclk_pin, ssel_pin}),
    .lvl_o(sync_lvl), .rise_o(sync_rise), .primed_o(primed)
  );

  spi_ssel_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .ssel_lvl_i(sync_lvl[0]),
    .sclk_rise_i(sync_rise[1]), .primed_i(primed), .abort_i(abort), .hit_i(hit),
    .state_o(state), .start_o(start), .counting_o(counting), .leave_o(leave),
    .end3_o(end3), .abort_end_o(abort_end)
  );

  spi_ssel_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .start_i(start), .counting_i(counting),
    .edge_i(sync_rise[1]), .len_i(len_eff), .cnt_o(bit_cnt), .hit_o(hit)
  );

  spi_ssel_flags u_flags (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .start_i(start), .hit_i(hit),
    .leave_i(leave), .filled_i(state == ST_FILLED), .end3_i(end3),
    .abort_end_i(abort_end), .done_clr_i(done_clr), .start_clr_i(start_clr),
    .done_o(done_flag), .met_o(len_met), .start_sts_o(start_sts), .start_irq_o(start_irq)
  );

  assign busy = (state != ST_IDLE);

  logic unused_lvl;
  assign unused_lvl = sync_lvl[1] ^ sync_rise[0];
endmodule

// File: rtl/spi_ssel_frontend_chk.sv
module spi_ssel_frontend_chk #(
  parameter int MAX_BITS = 32,
  parameter int CNT_W    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             three_wire,
  input logic             abort,
  input logic             done_clr,
  input logic             busy,
  input logic             done_flag,
  input logic             start_sts,
  input logic [CNT_W-1:0] bit_cnt
);
  // R9
  abort_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (three_wire && busy && abort) |=> (!busy && done_flag && !start_sts));

  // R8
  start_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_sts) |-> ($rose(busy) && three_wire));

  // R11
  done_only_by_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> $past(done_clr));

  // R12
  cnt_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bit_cnt <= CNT_W'(1)));

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(MAX_BITS));
endmodule

bind spi_ssel_frontend spi_ssel_frontend_chk #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .three_wire(three_wire), .abort(abort),
  .done_clr(done_clr), .busy(busy), .done_flag(done_flag),
  .start_sts(start_sts), .bit_cnt(bit_cnt)
);

// File: tb/spi_ssel_frontend_test.sv
module spi_ssel_frontend_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ssel_pin = 1'b1, sclk_pin = 1'b0;
  logic ssel_act_high = 1'b0, level_mode = 1'b0, three_wire = 1'b0;
  logic inactive_done_en = 1'b0, start_ie = 1'b0;
  logic [4:0] word_len = 5'd8;
  logic done_clr = 1'b0, start_clr = 1'b0, abort = 1'b0;
  logic busy, done_flag, len_met, start_sts, start_irq;
  logic [5:0] bit_cnt;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    logic b, d, m, s, i;
    logic [5:0] c;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  spi_ssel_frontend uut (
    .clk(clk), .rst_n(rst_n), .ssel_pin(ssel_pin), .sclk_pin(sclk_pin),
    .ssel_act_high(ssel_act_high), .level_mode(level_mode), .three_wire(three_wire),
    .inactive_done_en(inactive_done_en), .start_ie(start_ie), .word_len(word_len),
    .done_clr(done_clr), .start_clr(start_clr), .abort(abort),
    .busy(busy), .done_flag(done_flag), .len_met(len_met), .start_sts(start_sts),
    .start_irq(start_irq), .bit_cnt(bit_cnt)
  );

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      wait (sb.size() != 0);
      begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if ({busy, done_flag, len_met, start_sts, start_irq, bit_cnt} !==
            {e.b, e.d, e.m, e.s, e.i, e.c}) begin
          bad++;
          $display("FAIL %s: got busy=%0b done=%0b met=%0b sts=%0b irq=%0b cnt=%0d exp busy=%0b done=%0b met=%0b sts=%0b irq=%0b cnt=%0d",
                   e.tag, busy, done_flag, len_met, start_sts, start_irq, bit_cnt,
                   e.b, e.d, e.m, e.s, e.i, e.c);
        end
      end
    end
  end

  task automatic expect_now(string tag, logic b, logic d, logic m, logic s, logic i, int c);
    exp_t e;
    e.tag = tag; e.b = b; e.d = d; e.m = m; e.s = s; e.i = i; e.c = 6'(c);
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clocks(int n);
    for (int k = 0; k < n; k++) begin
      sclk_pin = 1'b1;
      repeat (3) @(negedge clk);
      sclk_pin = 1'b0;
      repeat (3) @(negedge clk);
    end
    settle();
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R1 in reset", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    settle();
    expect_now("R1 after reset", 0, 0, 0, 0, 0, 0);

    // edge mode, active low
    ssel_pin = 1'b0; settle();
    expect_now("R2 R3 falling edge starts", 1, 0, 0, 0, 0, 0);
    clocks(7);
    expect_now("R12 counting", 1, 0, 0, 0, 0, 7);
    clocks(1);
    expect_now("R3 length ends", 0, 1, 0, 0, 0, 8);
    pulse(done_clr);
    expect_now("R11 done cleared", 0, 0, 0, 0, 0, 8);
    clocks(3);
    expect_now("R3 held select ignored", 0, 0, 0, 0, 0, 8);
    ssel_pin = 1'b1; settle();
    expect_now("R2 rising edge not active", 0, 0, 0, 0, 0, 8);

    // level mode, active high
    ssel_pin = 1'b0; settle();
    ssel_act_high = 1'b1; level_mode = 1'b1; settle();
    ssel_pin = 1'b1; settle();
    expect_now("R4 R12 level start", 1, 0, 0, 0, 0, 0);
    clocks(5);
    expect_now("R4 partial", 1, 0, 0, 0, 0, 5);
    ssel_pin = 1'b0; settle();
    expect_now("R5 R6 short release", 0, 0, 0, 0, 0, 5);
    ssel_pin = 1'b1; settle();
    clocks(8);
    expect_now("R4 full still open", 1, 1, 0, 0, 0, 8);
    clocks(2);
    expect_now("R4 extra clocks ignored", 1, 1, 0, 0, 0, 8);
    ssel_pin = 1'b0; settle();
    expect_now("R5 met on release", 0, 1, 1, 0, 0, 8);
    pulse(done_clr);
    inactive_done_en = 1'b1;
    ssel_pin = 1'b1; settle();
    clocks(3);
    ssel_pin = 1'b0; settle();
    expect_now("R6 release sets done", 0, 1, 0, 0, 0, 3);
    pulse(done_clr);
    inactive_done_en = 1'b0;

    // three-wire
    three_wire = 1'b1; start_ie = 1'b1; settle();
    ssel_pin = 1'b1; settle(); ssel_pin = 1'b0; settle();
    expect_now("R7 pin ignored", 0, 0, 0, 0, 0, 3);
    clocks(1);
    expect_now("R7 R8 first clock starts", 1, 0, 0, 1, 1, 1);
    clocks(7);
    expect_now("R7 R8 completion", 0, 1, 1, 0, 0, 8);
    pulse(done_clr);
    clocks(2);
    expect_now("R8 second start", 1, 0, 1, 1, 1, 2);
    pulse(start_clr);
    expect_now("R8 start_clr", 1, 0, 1, 0, 0, 2);
    pulse(abort);
    expect_now("R9 abort ends", 0, 1, 0, 0, 0, 2);
    pulse(done_clr);
    pulse(abort);
    expect_now("R9 idle abort no effect", 0, 0, 0, 0, 0, 2);
    start_ie = 1'b0;
    clocks(1);
    expect_now("R8 irq masked", 1, 0, 0, 1, 0, 1);
    pulse(abort);
    pulse(done_clr);
    word_len = 5'd0;
    clocks(31);
    expect_now("R10 31 of 32", 1, 0, 0, 1, 0, 31);
    clocks(1);
    expect_now("R10 32 bits done", 0, 1, 1, 0, 0, 32);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule